// File: doc/BRIEF.md
# DRAM Request Address Decoder

This block turns a physical request address owned by one memory controller into rank, bank, row and column coordinates. The system may spread memory across several controllers by striping on a fixed granularity. The decoder therefore first deletes the stripe-select bits and shifts the upper bits down. The result is a dense local address that runs from zero to the controller capacity, so the later field extraction does not depend on how the system interleaves. It then drops the byte offset inside a column burst and slices the remaining word index according to one of two field orderings.

The ordering is chosen per request by a two-bit code that is sampled with the address:

- **Open-page ordering** keeps a whole row buffer's columns at the bottom, so consecutive lines stay in one row.
- **Closed-page ordering** keeps only a small column stripe at the bottom and puts bank and rank bits directly above it. Consecutive stripes then spread across banks.

Requests use a valid/ready handshake. Each accepted request produces one registered result with a valid flag on the next clock edge. The geometry is set by parameters, and every count in it is a power of two. The geometry parameters are the interleave granularity, the stripe count, the columns per row and per stripe, and the banks, ranks and rows.

Top module: `dram_addr_decoder`

## Requirements
- R1: Interleave compaction. The local address is formed by removing the STRIPES_LOG2 bits that start at bit ILV_GRAN_LOG2 and shifting the bits above them down. Two addresses that differ only in those bits decode identically.
- R2: The lowest BURST_LOG2 address bits (the byte offset within a burst) have no effect on any output field.
- R3: Map code 0 selects the open-page ordering. Counting upward from the word index, the fields are the column (COL_LOG2 bits), then bank, then rank, then row.
- R4: Map code 1 selects the closed-page ordering. Counting upward from the word index, the fields are:
  - the low column stripe (STRIPE_COL_LOG2 bits), which forms the column's low bits;
  - bank;
  - rank;
  - the remaining column bits, which form the column's high bits;
  - row.
- R5: The row is the word-index field taken modulo 2^ROW_LOG2. Local address bits above the row field have no effect.
- R6: Map codes 2 and 3 give out_err=1 with rank, bank, row and column all zero.
- R7: Map code 0 gives out_err=1 with zero fields when interleaving is configured (STRIPES_LOG2>0) and ILV_GRAN_LOG2 differs from BURST_LOG2+COL_LOG2. Map code 1 is unaffected by this condition.
- R8: out_valid is 1 exactly in the cycle after a request is accepted (req_valid and req_ready both 1 at a rising edge). Without an accepted request, the output fields hold their values.
- R9: While reset is asserted, and for two rising edges after it is released, req_ready is 0. During reset out_valid and out_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can accept a request |
| req_addr | input | ADDR_W | Physical request address |
| req_map | input | 2 | Field ordering: 0 open-page, 1 closed-page, others invalid |
| out_valid | output | 1 | Decoded result present |
| out_err | output | 1 | Unsupported ordering or configuration |
| out_rank | output | RANK_LOG2 | Rank index |
| out_bank | output | BANK_LOG2 | Bank index |
| out_row | output | ROW_LOG2 | Row index |
| out_col | output | COL_LOG2 | Column index within the row buffer |

## Verification
- **Result timing.** Every decoded field, the error flag and out_valid are due on the first rising edge after the edge that accepts the request. req_ready is due two edges after reset is released.
- **Drive and sample points.** The bench drives each request just after a falling edge and reads the result at the next falling edge. Each sample therefore lands half a period after the one register stage. After an idle cycle it reads again to confirm that out_valid has dropped and that the fields held.
- **Second instance.** A second instance with a mismatched granularity shares the inputs. It is read at the same points to cover the configuration error.

// File: rtl/dram_addr_decoder_pkg.sv
package dram_addr_decoder_pkg;
  typedef enum logic [1:0] {
    MAP_OPEN   = 2'd0,
    MAP_CLOSED = 2'd1
  } map_e;
endpackage

// File: rtl/dad_rst_sync.sv
module dad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dad_compact.sv
module dad_compact #(
  parameter int ADDR_W        = 32,
  parameter int STRIPES_LOG2  = 1,
  parameter int ILV_GRAN_LOG2 = 11,
  localparam int LOC_W        = ADDR_W - STRIPES_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc
);
  generate
    if (STRIPES_LOG2 == 0) begin : g_flat
      assign loc = addr;
    end else begin : g_squeeze
      localparam logic [ADDR_W-1:0] LO_MASK = (ADDR_W'(1) << ILV_GRAN_LOG2) - ADDR_W'(1);
      logic [ADDR_W-1:0] lo_part;
      logic [ADDR_W-1:0] hi_part;
      assign lo_part = addr & LO_MASK;
      assign hi_part = (addr >> (ILV_GRAN_LOG2 + STRIPES_LOG2)) << ILV_GRAN_LOG2;
      assign loc     = LOC_W'(hi_part | lo_part);
    end
  endgenerate
endmodule

// File: rtl/dad_fieldmap.sv
module dad_fieldmap
  import dram_addr_decoder_pkg::*;
#(
  parameter int LOC_W           = 31,
  parameter int BURST_LOG2      = 6,
  parameter int COL_LOG2        = 5,
  parameter int STRIPE_COL_LOG2 = 2,
  parameter int BANK_LOG2       = 3,
  parameter int RANK_LOG2       = 1,
  parameter int ROW_LOG2        = 14,
  parameter bit OPEN_CFG_BAD    = 1'b0
) (
  input  logic [LOC_W-1:0]     loc,
  input  logic [1:0]           map,
  output logic [RANK_LOG2-1:0] rank,
  output logic [BANK_LOG2-1:0] bank,
  output logic [ROW_LOG2-1:0]  row,
  output logic [COL_LOG2-1:0]  col,
  output logic                 err
);
  localparam int CHI_W     = COL_LOG2 - STRIPE_COL_LOG2;
  localparam int O_BANK_AT = COL_LOG2;
  localparam int O_RANK_AT = COL_LOG2 + BANK_LOG2;
  localparam int C_BANK_AT = STRIPE_COL_LOG2;
  localparam int C_RANK_AT = STRIPE_COL_LOG2 + BANK_LOG2;
  localparam int C_CHI_AT  = STRIPE_COL_LOG2 + BANK_LOG2 + RANK_LOG2;
  localparam int ROW_AT    = COL_LOG2 + BANK_LOG2 + RANK_LOG2;

  logic [LOC_W-1:0] word;
  assign word = loc >> BURST_LOG2;

  always_comb begin
    rank = '0;
    bank = '0;
    row  = '0;
    col  = '0;
    err  = 1'b0;
    case (map)
      MAP_OPEN: begin
        if (OPEN_CFG_BAD) begin
          err = 1'b1;
        end else begin
          col  = COL_LOG2'(word);
          bank = BANK_LOG2'(word >> O_BANK_AT);
          rank = RANK_LOG2'(word >> O_RANK_AT);
          row  = ROW_LOG2'(word >> ROW_AT);
        end
      end
      MAP_CLOSED: begin
        col  = {CHI_W'(word >> C_CHI_AT), STRIPE_COL_LOG2'(word)};
        bank = BANK_LOG2'(word >> C_BANK_AT);
        rank = RANK_LOG2'(word >> C_RANK_AT);
        row  = ROW_LOG2'(word >> ROW_AT);
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/dram_addr_decoder.sv
module dram_addr_decoder #(
  parameter int ADDR_W          = 32,
  parameter int BURST_LOG2      = 6,
  parameter int COL_LOG2        = 5,
  parameter int STRIPE_COL_LOG2 = 2,
  parameter int BANK_LOG2       = 3,
  parameter int RANK_LOG2       = 1,
  parameter int ROW_LOG2        = 14,
  parameter int STRIPES_LOG2    = 1,
  parameter int ILV_GRAN_LOG2   = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_map,
  output logic                 out_valid,
  output logic                 out_err,
  output logic [RANK_LOG2-1:0] out_rank,
  output logic [BANK_LOG2-1:0] out_bank,
  output logic [ROW_LOG2-1:0]  out_row,
  output logic [COL_LOG2-1:0]  out_col
);
  localparam int LOC_W       = ADDR_W - STRIPES_LOG2;
  localparam bit OPEN_CFG_BAD = (STRIPES_LOG2 != 0) &&
                                (ILV_GRAN_LOG2 != BURST_LOG2 + COL_LOG2);

  logic                 srst_n;
  logic                 accept;
  logic [LOC_W-1:0]     loc;
  logic [RANK_LOG2-1:0] f_rank;
  logic [BANK_LOG2-1:0] f_bank;
  logic [ROW_LOG2-1:0]  f_row;
  logic [COL_LOG2-1:0]  f_col;
  logic                 f_err;

  logic                 valid_d, valid_q;
  logic                 err_d,   err_q;
  logic [RANK_LOG2-1:0] rank_d,  rank_q;
  logic [BANK_LOG2-1:0] bank_d,  bank_q;
  logic [ROW_LOG2-1:0]  row_d,   row_q;
  logic [COL_LOG2-1:0]  col_d,   col_q;

  dad_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dad_compact #(
    .ADDR_W        (ADDR_W),
    .STRIPES_LOG2  (STRIPES_LOG2),
    .ILV_GRAN_LOG2 (ILV_GRAN_LOG2)
  ) u_compact (
    .addr (req_addr),
    .loc  (loc)
  );

  dad_fieldmap #(
    .LOC_W           (LOC_W),
    .BURST_LOG2      (BURST_LOG2),
    .COL_LOG2        (COL_LOG2),
    .STRIPE_COL_LOG2 (STRIPE_COL_LOG2),
    .BANK_LOG2       (BANK_LOG2),
    .RANK_LOG2       (RANK_LOG2),
    .ROW_LOG2        (ROW_LOG2),
    .OPEN_CFG_BAD    (OPEN_CFG_BAD)
  ) u_fieldmap (
    .loc  (loc),
    .map  (req_map),
    .rank (f_rank),
    .bank (f_bank),
    .row  (f_row),
    .col  (f_col),
    .err  (f_err)
  );

  assign req_ready = srst_n;
  assign accept    = req_valid & req_ready;

  always_comb begin
    valid_d = accept;
    err_d   = err_q;
    rank_d  = rank_q;
    bank_d  = bank_q;
    row_d   = row_q;
    col_d   = col_q;
    if (accept) begin
      err_d  = f_err;
      rank_d = f_rank;
      bank_d = f_bank;
      row_d  = f_row;
      col_d  = f_col;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rank_q  <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      rank_q  <= rank_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_rank  = rank_q;
  assign out_bank  = bank_q;
  assign out_row   = row_q;
  assign out_col   = col_q;
endmodule

// File: rtl/dram_addr_decoder_chk.sv
module dram_addr_decoder_chk #(
  parameter int ADDR_W    = 32,
  parameter int COL_W     = 5,
  parameter int BANK_W    = 3,
  parameter int RANK_W    = 1,
  parameter int ROW_W     = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_map,
  input logic              out_valid,
  input logic              out_err,
  input logic [RANK_W-1:0] out_rank,
  input logic [BANK_W-1:0] out_bank,
  input logic [ROW_W-1:0]  out_row,
  input logic [COL_W-1:0]  out_col
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R8

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid); // R8

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(out_row) && $stable(out_col) && $stable(out_bank) &&
              $stable(out_rank) && $stable(out_err))); // R8

  AST_BAD_CODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_map[1]) |=> out_err); // R6

  AST_ERR_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_row == '0 && out_col == '0 && out_bank == '0 &&
                 out_rank == '0)); // R6

  AST_ADDR_KNOWN_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !$isunknown(req_addr)); // R1
endmodule

bind dram_addr_decoder dram_addr_decoder_chk #(
  .ADDR_W (ADDR_W),
  .COL_W  (COL_LOG2),
  .BANK_W (BANK_LOG2),
  .RANK_W (RANK_LOG2),
  .ROW_W  (ROW_LOG2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_map   (req_map),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_rank  (out_rank),
  .out_bank  (out_bank),
  .out_row   (out_row),
  .out_col   (out_col)
);

// File: tb/dram_addr_decoder_test.sv
module dram_addr_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_map;
  logic        out_valid, out_err;
  logic [0:0]  out_rank;
  logic [2:0]  out_bank;
  logic [13:0] out_row;
  logic [4:0]  out_col;
  logic        bad_ready, bad_valid, bad_err;
  logic [0:0]  bad_rank;
  logic [2:0]  bad_bank;
  logic [13:0] bad_row;
  logic [4:0]  bad_col;

  int checks = 0;
  int errors = 0;

  dram_addr_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_map(req_map), .out_valid(out_valid),
    .out_err(out_err), .out_rank(out_rank), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col)
  );

  dram_addr_decoder #(.ILV_GRAN_LOG2(9)) uut_bad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(bad_ready),
    .req_addr(req_addr), .req_map(req_map), .out_valid(bad_valid),
    .out_err(bad_err), .out_rank(bad_rank), .out_bank(bad_bank),
    .out_row(bad_row), .out_col(bad_col)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected decode for the default geometry: 6 offset bits, 32 columns,
  // stripe of 4 columns, 8 banks, 2 ranks, 16384 rows, 2 stripes of 2 KiB.
  function automatic void model(input logic [31:0] a, input logic [1:0] m,
                                output logic e, output logic [0:0] rk,
                                output logic [2:0] bk, output logic [13:0] rw,
                                output logic [4:0] cl);
    longint unsigned loc, w;
    loc = ((longint'(a) >> 12) << 11) | (longint'(a) & 64'h7FF);
    w   = loc >> 6;
    e = 1'b0; rk = '0; bk = '0; rw = '0; cl = '0;
    if (m == 2'd0) begin
      cl = 5'(w & 31);
      bk = 3'((w >> 5) & 7);
      rk = 1'((w >> 8) & 1);
      rw = 14'((w >> 9) & 16383);
    end else if (m == 2'd1) begin
      cl = 5'((((w >> 6) & 7) << 2) | (w & 3));
      bk = 3'((w >> 2) & 7);
      rk = 1'((w >> 5) & 1);
      rw = 14'((w >> 9) & 16383);
    end else begin
      e = 1'b1;
    end
  endfunction

  task automatic send(input logic [31:0] a, input logic [1:0] m, input string req);
    logic e; logic [0:0] rk; logic [2:0] bk; logic [13:0] rw; logic [4:0] cl;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_map = m;
    @(negedge clk);
    req_valid = 1'b0;
    model(a, m, e, rk, bk, rw, cl);
    check(req, "out_valid", out_valid, 1'b1);
    check(req, "out_err",   out_err,   e);
    check(req, "out_rank",  out_rank,  rk);
    check(req, "out_bank",  out_bank,  bk);
    check(req, "out_row",   out_row,   rw);
    check(req, "out_col",   out_col,   cl);
  endtask

  initial begin
    logic [13:0] row_a; logic [4:0] col_a; logic [2:0] bank_a; logic [0:0] rank_a;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_map = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "req_ready in reset", req_ready, 1'b0);
    check("R9", "out_valid in reset", out_valid, 1'b0);
    check("R9", "out_err in reset",   out_err,   1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "req_ready one edge after release", req_ready, 1'b0);
    @(negedge clk);
    check("R9", "req_ready two edges after release", req_ready, 1'b1);

    // R3 / R4 directed field walks
    send(32'h0000_0040, 2'd0, "R3");
    send(32'h0000_0800 | 32'h0000_1000, 2'd0, "R3");
    send(32'h0000_0100, 2'd1, "R4");
    send(32'h0000_7FC0, 2'd1, "R4");

    // R1: stripe bit 11 cleared vs set decodes identically
    send(32'h1234_5078 & ~32'h800, 2'd0, "R1");
    row_a = out_row; col_a = out_col; bank_a = out_bank; rank_a = out_rank;
    send(32'h1234_5078 | 32'h800, 2'd0, "R1");
    check("R1", "row equal across stripe bit",  out_row,  row_a);
    check("R1", "col equal across stripe bit",  out_col,  col_a);
    check("R1", "bank equal across stripe bit", out_bank, bank_a);
    check("R1", "rank equal across stripe bit", out_rank, rank_a);

    // R2: byte offset bits have no effect
    send(32'h0ABC_D400, 2'd1, "R2");
    row_a = out_row; col_a = out_col;
    send(32'h0ABC_D43F, 2'd1, "R2");
    check("R2", "row equal across offset", out_row, row_a);
    check("R2", "col equal across offset", out_col, col_a);

    // R5: top address bits above the row field are ignored
    send(32'hC000_0000, 2'd0, "R5");
    check("R5", "row zero for top bits only", out_row, 14'd0);
    send(32'hFFFF_FFFF, 2'd1, "R5");

    // R6: unsupported codes
    send(32'h5555_5555, 2'd2, "R6");
    send(32'hAAAA_AAAA, 2'd3, "R6");

    // R7: mismatched granularity instance
    send(32'h0003_0240, 2'd0, "R3");
    check("R7", "bad cfg open err",  bad_err, 1'b1);
    check("R7", "bad cfg open row",  bad_row, 14'd0);
    send(32'h0003_0240, 2'd1, "R4");
    check("R7", "bad cfg closed err", bad_err, 1'b0);

    // R8: idle cycle drops valid and holds fields
    row_a = out_row; col_a = out_col;
    @(negedge clk);
    check("R8", "out_valid after idle", out_valid, 1'b0);
    check("R8", "row held",             out_row,   row_a);
    check("R8", "col held",             out_col,   col_a);

    // random mix (R3, R4, R6)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      m = ($urandom % 8 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
      send($urandom, m, m == 2'd0 ? "R3" : (m == 2'd1 ? "R4" : "R6"));
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        check("R8", "out_valid idle random", out_valid, 1'b0);
      end
    end

    summary();
    $finish;
  end
endmodule